// File: doc/BRIEF.md
# Prescaled Reload Down-Counter Timer

This block is one timer channel: a 32-bit down-counter paced by a selectable power-of-four division of the peripheral clock, with a 32-bit reload constant and a 16-bit control register. Software reaches all three through a small word-addressed register port with select, write enable, address, write data and combinational read data. The counter moves only while the external `start` input is high. When `start` falls, the count freezes where it is.

When the counter is paced down from zero, it takes the reload constant instead of wrapping. It also sets a sticky underflow flag. The interrupt output is that flag gated by an enable bit. Software clears the flag by writing the control register with the flag bit at zero. Writing it at one leaves the flag as it is.

The clock-edge and capture fields of the control register have no function here. They are stored and read back as written.

Top module: `reload_timer`

## Requirements
- R1: After reset the reload register (address 0) and the counter (address 1) read 0xFFFFFFFF, the control register (address 2) reads 0, and `irq` is low.
- R2: A write loads only the addressed register, and reads return it. Control bits [15:10] are ignored on write and read as 0. Control bits [7:0] and bit 9 read back as written. Address 3 reads 0, and writes to it do nothing. While `sel` is low, `rdata` is 0.
- R3: The prescale code in control bits [2:0] paces the counter:
  - codes 0, 1, 2, 3 and 4 give one counter step every 4, 16, 64, 256 and 1024 clocks of running time;
  - codes 5, 6 and 7 give no steps.
- R4: The counter and the prescaler advance only while `start` is high. With `start` low the count holds its value.
- R5: A step from a nonzero count decrements it. A step from zero loads the reload value and sets the underflow flag (control bit 8).
- R6: A control write with bit 8 at 0 clears the underflow flag. A write with bit 8 at 1 leaves it unchanged.
- R7: `irq` is high exactly when the underflow flag and the interrupt enable (control bit 5) are both 1.
- R8: If an underflow and a flag-clearing control write fall in the same cycle, the flag ends set.
- R9: If a counter write and a counter step fall in the same cycle, the written value is kept, and that step does not set the flag.
- R10: Every control write restarts the prescaler phase. The next step comes a full division period after the write.
- R11: Writing the reload register does not change the current count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Count enable for this channel |
| sel | input | 1 | Register port select |
| we | input | 1 | Write enable, qualified by `sel` |
| addr | input | 2 | Word address: 0 reload, 1 counter, 2 control |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed register |
| irq | output | 1 | Underflow interrupt level |

## Verification
Two events can land on the same rising edge:
- an underflow, which sets the flag and reloads the count;
- a register write that touches the same state, either a control write clearing the flag or a counter write.

The bench provokes both collisions. It starts the counter at zero with the divide-by-4 code, waits three running clocks, then times the write so that it is sampled on the fourth edge, which carries the step. For the flag case it expects control to read 0x0120, the counter to hold the reload value and `irq` to be high. For the counter case it expects the written value and an unchanged flag.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;
  // control register bit positions that software relies on
  localparam int B_PSC  = 0;
  localparam int B_EDGE = 3;
  localparam int B_UIE  = 5;
  localparam int B_CAP  = 6;
  localparam int B_UF   = 8;
  localparam int B_CAPF = 9;
  localparam int USED_CTRL_BITS = 10;

  // word addresses
  localparam int A_RELOAD = 0;
  localparam int A_COUNT  = 1;
  localparam int A_CTRL   = 2;
endpackage

// File: rtl/rtmr_prescale.sv
module rtmr_prescale #(
  parameter int RATIOS = 5,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clear,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int PW    = 2 * RATIOS;
  localparam int CODES = 2 ** CODE_W;

  logic [PW-1:0]    pcnt_q, pcnt_d;
  logic [CODES-1:0] term;

  // terminal count for code g is 4^(g+1)-1; codes beyond RATIOS never match
  for (genvar g = 0; g < CODES; g++) begin : g_term
    if (g < RATIOS) begin : g_ok
      assign term[g] = &pcnt_q[2*g+1:0];
    end else begin : g_rsv
      assign term[g] = 1'b0;
    end
  end

  assign tick = run && term[code];

  always_comb begin
    pcnt_d = pcnt_q;
    if (clear) begin
      pcnt_d = '0;
    end else if (run) begin
      pcnt_d = tick ? '0 : pcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end
endmodule

// File: rtl/rtmr_counter.sv
module rtmr_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         cor_wr,
  input  logic         cnt_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cor_q,
  output logic         uflow
);
  logic [W-1:0] cnt_d, cor_d;
  logic         at_zero;

  assign at_zero = (cnt_q == '0);
  // a bus write to the count takes the cycle, so no underflow is reported then
  assign uflow   = tick && at_zero && !cnt_wr;

  always_comb begin
    cnt_d = cnt_q;
    cor_d = cor_q;
    if (cor_wr) cor_d = wdata;
    if (cnt_wr) begin
      cnt_d = wdata;
    end else if (tick) begin
      cnt_d = at_zero ? cor_q : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      cor_q <= '1;
    end else begin
      cnt_q <= cnt_d;
      cor_q <= cor_d;
    end
  end
endmodule

// File: rtl/rtmr_ctrl.sv
module rtmr_ctrl #(
  parameter int CTRL_W = 16,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              uf_set,
  output logic [CTRL_W-1:0] ctrl_rd,
  output logic [CODE_W-1:0] psc,
  output logic              uie,
  output logic              uf
);
  import rtmr_pkg::*;
  localparam int RSV_W = CTRL_W - USED_CTRL_BITS;

  logic [CODE_W-1:0] psc_q, psc_d;
  logic [1:0]        edge_q, edge_d, cap_q, cap_d;
  logic              uie_q, uie_d, capf_q, capf_d, uf_q, uf_d;

  always_comb begin
    psc_d  = psc_q;
    edge_d = edge_q;
    cap_d  = cap_q;
    uie_d  = uie_q;
    capf_d = capf_q;
    uf_d   = uf_q;
    if (wr_en) begin
      psc_d  = wdata[B_PSC +: CODE_W];
      edge_d = wdata[B_EDGE +: 2];
      uie_d  = wdata[B_UIE];
      cap_d  = wdata[B_CAP +: 2];
      capf_d = wdata[B_CAPF];
      if (!wdata[B_UF]) uf_d = 1'b0;
    end
    // hardware set outranks a software clear
    if (uf_set) uf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q  <= '0;
      edge_q <= '0;
      cap_q  <= '0;
      uie_q  <= 1'b0;
      capf_q <= 1'b0;
      uf_q   <= 1'b0;
    end else begin
      psc_q  <= psc_d;
      edge_q <= edge_d;
      cap_q  <= cap_d;
      uie_q  <= uie_d;
      capf_q <= capf_d;
      uf_q   <= uf_d;
    end
  end

  assign ctrl_rd = {{RSV_W{1'b0}}, capf_q, uf_q, cap_q, uie_q, edge_q, psc_q};
  assign psc     = psc_q;
  assign uie     = uie_q;
  assign uf      = uf_q;
endmodule

// File: rtl/reload_timer.sv
module reload_timer #(
  parameter int DATA_W     = 32,
  parameter int CTRL_W     = 16,
  parameter int ADDR_W     = 2,
  parameter int PSC_RATIOS = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  import rtmr_pkg::*;
  localparam int CODE_W = $clog2(PSC_RATIOS);
  localparam logic [ADDR_W-1:0] AD_RELOAD = ADDR_W'(A_RELOAD);
  localparam logic [ADDR_W-1:0] AD_COUNT  = ADDR_W'(A_COUNT);
  localparam logic [ADDR_W-1:0] AD_CTRL   = ADDR_W'(A_CTRL);

  logic              wr, tcor_wr, tcnt_wr, tcr_wr;
  logic              tick, uflow, uie, uf;
  logic [CODE_W-1:0] psc;
  logic [DATA_W-1:0] tcnt_q, tcor_q;
  logic [CTRL_W-1:0] ctrl_rd;

  assign wr      = sel && we;
  assign tcor_wr = wr && (addr == AD_RELOAD);
  assign tcnt_wr = wr && (addr == AD_COUNT);
  assign tcr_wr  = wr && (addr == AD_CTRL);

  rtmr_prescale #(.RATIOS(PSC_RATIOS), .CODE_W(CODE_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(start), .clear(tcr_wr),
    .code(psc), .tick(tick)
  );

  rtmr_counter #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cor_wr(tcor_wr),
    .cnt_wr(tcnt_wr), .wdata(wdata), .cnt_q(tcnt_q), .cor_q(tcor_q),
    .uflow(uflow)
  );

  rtmr_ctrl #(.CTRL_W(CTRL_W), .CODE_W(CODE_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(tcr_wr), .wdata(wdata[CTRL_W-1:0]),
    .uf_set(uflow), .ctrl_rd(ctrl_rd), .psc(psc), .uie(uie), .uf(uf)
  );

  always_comb begin
    rdata = '0;
    if (sel) begin
      if (addr == AD_RELOAD)     rdata = tcor_q;
      else if (addr == AD_COUNT) rdata = tcnt_q;
      else if (addr == AD_CTRL)  rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_rd};
    end
  end

  assign irq = uf && uie;
endmodule

// File: rtl/rtmr_checker.sv
module rtmr_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         tick,
  input logic         rsv_code,
  input logic [W-1:0] cnt,
  input logic [W-1:0] cor,
  input logic         cnt_wr,
  input logic         clr_req,
  input logic         uf,
  input logic         uie,
  input logic         irq
);
  logic wrap;
  assign wrap = tick && (cnt == '0) && !cnt_wr;

  AST_TICK_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    !start |-> !tick);                                            // R4
  AST_FROZEN_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !cnt_wr) |=> $stable(cnt));                        // R4
  AST_RESERVED_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_code |-> !tick);                                          // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (cnt != '0) && !cnt_wr) |=> (cnt == $past(cnt) - 1'b1)); // R5
  AST_RELOAD_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == $past(cor)));                                // R5
  AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> uf);                                                 // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && !clr_req) |=> uf);                                     // R6
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !uie |-> !irq);                                               // R7
endmodule

bind reload_timer rtmr_checker #(.W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
  .rsv_code(int'(psc) >= PSC_RATIOS), .cnt(tcnt_q), .cor(tcor_q),
  .cnt_wr(tcnt_wr), .clr_req(tcr_wr && !wdata[rtmr_pkg::B_UF]),
  .uf(uf), .uie(uie), .irq(irq)
);

// File: tb/reload_timer_test.sv
`timescale 1ns/1ps
module reload_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        sel = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  reload_timer uut (
    .clk(clk), .rst_n(rst_n), .start(start), .sel(sel), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // write/readback table (R2)
  localparam int NV = 6;
  localparam logic [1:0]  V_ADDR [NV] = '{2'd0, 2'd1, 2'd2, 2'd2, 2'd2, 2'd3};
  localparam logic [31:0] V_DATA [NV] = '{32'h12345678, 32'h0000ABCD, 32'h0000FFFF,
                                          32'h00000123, 32'h00007C5A, 32'hFFFFFFFF};
  localparam logic [31:0] V_EXP  [NV] = '{32'h12345678, 32'h0000ABCD, 32'h000002FF,
                                          32'h00000023, 32'h0000005A, 32'h00000000};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    sel = 1'b1; we = 1'b0; addr = a;
    #1;
    d = rdata;
    sel = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); check("R1 reload", v, 32'hFFFFFFFF);
    rd(2'd1, v); check("R1 count", v, 32'hFFFFFFFF);
    rd(2'd2, v); check("R1 control", v, 32'h0);
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R2 rdata idle", rdata, 32'd0);

    // R2 table walk
    for (int i = 0; i < NV; i++) begin
      wr(V_ADDR[i], V_DATA[i]);
      rd(V_ADDR[i], v);
      check("R2 readback", v, V_EXP[i]);
    end

    // R5/R7 underflow at divide-by-4 with interrupt enabled
    wr(2'd2, 32'h0020); wr(2'd1, 32'd2); wr(2'd0, 32'd5);
    start = 1'b1;
    repeat (11) @(posedge clk); @(negedge clk);
    rd(2'd1, v); check("R5 count before wrap", v, 32'd0);
    check("R7 irq before wrap", {31'd0, irq}, 32'd0);
    @(posedge clk); @(negedge clk);
    rd(2'd1, v); check("R5 reload on wrap", v, 32'd5);
    rd(2'd2, v); check("R5 flag set", v, 32'h0120);
    check("R7 irq on", {31'd0, irq}, 32'd1);

    // R4 freeze
    start = 1'b0;
    repeat (20) @(posedge clk); @(negedge clk);
    rd(2'd1, v); check("R4 frozen", v, 32'd5);

    // R6 flag write semantics
    wr(2'd2, 32'h0120);
    rd(2'd2, v); check("R6 write one keeps flag", v, 32'h0120);
    wr(2'd2, 32'h0000);
    rd(2'd2, v); check("R6 write zero clears", v, 32'h0000);
    check("R7 irq off after clear", {31'd0, irq}, 32'd0);

    // R7 flag without enable
    wr(2'd1, 32'd0);
    start = 1'b1;
    repeat (4) @(posedge clk); @(negedge clk);
    start = 1'b0;
    rd(2'd2, v); check("R7 flag without enable", v, 32'h0100);
    check("R7 irq masked", {31'd0, irq}, 32'd0);
    wr(2'd2, 32'h0120);
    check("R7 irq after enable", {31'd0, irq}, 32'd1);

    // R3 all valid ratios
    for (int k = 0; k < 5; k++) begin
      wr(2'd2, k); wr(2'd1, 32'd0); wr(2'd0, 32'd100 + k);
      start = 1'b1;
      repeat ((4 << (2 * k)) - 1) @(posedge clk); @(negedge clk);
      rd(2'd1, v); check("R3 one clock early", v, 32'd0);
      @(posedge clk); @(negedge clk);
      rd(2'd1, v); check("R3 step on period", v, 32'd100 + k);
      start = 1'b0;
    end

    // R3 reserved codes
    for (int k = 5; k < 8; k++) begin
      wr(2'd2, k); wr(2'd1, 32'd3);
      start = 1'b1;
      repeat (1100) @(posedge clk); @(negedge clk);
      start = 1'b0;
      rd(2'd1, v); check("R3 reserved code idle", v, 32'd3);
    end

    // R10 control write restarts phase
    wr(2'd2, 32'h0); wr(2'd1, 32'd9);
    start = 1'b1;
    repeat (2) @(posedge clk);
    wr(2'd2, 32'h0);
    repeat (3) @(posedge clk); @(negedge clk);
    rd(2'd1, v); check("R10 no early step", v, 32'd9);
    @(posedge clk); @(negedge clk);
    rd(2'd1, v); check("R10 step after full period", v, 32'd8);
    start = 1'b0;

    // R8 underflow and flag clear in the same cycle
    wr(2'd2, 32'h0020); wr(2'd1, 32'd0); wr(2'd0, 32'h40);
    start = 1'b1;
    repeat (3) @(posedge clk);
    wr(2'd2, 32'h0020);
    rd(2'd2, v); check("R8 set beats clear", v, 32'h0120);
    rd(2'd1, v); check("R8 reload", v, 32'h40);
    check("R8 irq", {31'd0, irq}, 32'd1);
    start = 1'b0;

    // R9 counter write and step in the same cycle
    wr(2'd2, 32'h0020); wr(2'd1, 32'd0);
    start = 1'b1;
    repeat (3) @(posedge clk);
    wr(2'd1, 32'h55);
    start = 1'b0;
    rd(2'd1, v); check("R9 write wins", v, 32'h55);
    rd(2'd2, v); check("R9 no flag", v, 32'h0020);

    // R11 reload write leaves count
    wr(2'd0, 32'h99);
    rd(2'd1, v); check("R11 count kept", v, 32'h55);
    rd(2'd0, v); check("R11 reload loaded", v, 32'h99);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule